// File: doc/BRIEF.md
# Programmable Mealy logic sequencer

This block is a soft model of a field-programmable state sequencer. A user-loaded AND array of product terms looks at sixteen dedicated inputs, at the eight state bits and at two complement variables. A programmable OR array routes each term to the J and K inputs of sixteen J-K registers: eight state bits that feed back into the array and eight output bits that drive the pins. A complement variable is true when none of the terms in its group fires. One such term therefore covers the "otherwise" branch of a transition, so the else case needs no term of its own.

The whole configuration is loaded through a one-bit serial port while the registers are held at their initialization pattern. That configuration holds the array literals, the J/K connections, the complement groups, a sixteen-bit initialization pattern and two option bits. One option turns the init pin into an output enable. The other splits the registers into two halves: the upper half is clocked from input bit 5. A power-on reset presets every register to one and clears the configuration.

Top module: `mealy_seq_array`

## Requirements
- R1: While `por_n` is low, all sixteen registers read 1, so `f_pin` is 8'hFF, and the configuration is cleared to zero. With a cleared configuration every register holds after release.
- R2: Each array variable has a literal pair (pos, neg). 00 means don't care, 10 means the variable must be 1, 01 means it must be 0, and 11 means the term can never fire. Variable index 0-15 is `din`, 16-23 is state bit 0-7, and 24-25 is complement variable 0-1.
- R3: Each register takes J as the OR of the active terms connected to its J, and K likewise. J alone sets the bit, K alone clears it, J and K together toggle it, and with neither it holds. Register index 0-7 is state and 8-15 is output bit 0-7.
- R4: A complement variable is 1 when no member term of its group is active and 0 otherwise. Member terms are evaluated with their complement literals disregarded.
- R5: With option bit 0 clear, `init_pin` high asynchronously forces all registers to the pattern (pattern bit r goes to register r). They stay there while the pin is high, and normal stepping resumes afterwards.
- R6: With option bit 0 set, `init_pin` is an output enable. Low puts `f_pin` at high impedance, high drives the output register on `f_pin`, and the pin never initializes the registers.
- R7: With option bit 1 set, state bits 0-3 and output bits 0-3 advance on `clk`. State bits 4-7 and output bits 4-7 advance only on a rising `din[5]`, and the array reads `din[5]` as 0. With the bit clear, all registers use `clk` and `din[5]` is an ordinary input.
- R8: With `cfg_en` high, each rising `clk` shifts `cfg_din` into bit 0 of the configuration word, and every register loads the pattern the word holds after that shift. The word layout is: bits 1:0 options, bits 17:2 pattern, then 86 bits per term t from bit 18+86t. Within each term, bits 2v and 2v+1 are the pos and neg literal of variable v, then come 16 J bits, 16 K bits and 2 group bits. The bit sent first lands in the top bit.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| din | input | 16 | Dedicated inputs; bit 5 is the second clock when split |
| init_pin | input | 1 | Asynchronous initialization, or output enable |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Configuration serial data |
| f_pin | output | 8 | Output register pins, tri-stated when disabled |

## Verification
The J-K rules are checked on every `clk` cycle for the lower register half: hold, set, clear and toggle each follow the J and K that the array produces. The pattern load under `init_pin` and under `cfg_en` is checked on every cycle as well. The array programming itself, the complement-group behaviour, the upper half stepping on `din[5]` alone, the output-enable mode and power-on reset can only be shown by the bench scenarios. These run a small "101" sequence detector, a toggle bit, a never-firing term and a hold bit against a behavioural reference model.

// File: rtl/mealy_seq_array.sv
module mealy_seq_array #(
  parameter int NIN      = 16,
  parameter int NST      = 8,
  parameter int NOUT     = 8,
  parameter int NTERM    = 64,
  parameter int NCMP     = 2,
  parameter int CLK2_BIT = 5
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NIN-1:0]  din,
  input  logic            init_pin,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic [NOUT-1:0] f_pin
);
  localparam int NB   = NIN + NST;
  localparam int NVAR = NB + NCMP;
  localparam int NREG = NST + NOUT;
  localparam int TW   = 2*NVAR + 2*NREG + NCMP;
  localparam int OPTW = 2;
  localparam int BASE = OPTW + NREG;
  localparam int CW   = BASE + NTERM*TW;
  localparam int HS   = NST/2;
  localparam int HO   = NOUT/2;
  localparam int LW   = HS + HO;
  localparam int HW   = NREG - LW;

  logic [CW-1:0]    cfg_q;
  logic [LW-1:0]    lo_q;
  logic [HW-1:0]    hi_q;
  logic [NST-1:0]   st_q;
  logic [NOUT-1:0]  out_q;
  logic [NB-1:0]    xb;
  logic [NCMP-1:0]  cvar;
  logic [NTERM-1:0] term_nc, term;
  logic [NVAR-1:0]  apos [NTERM];
  logic [NVAR-1:0]  aneg [NTERM];
  logic [NTERM-1:0] jcol [NREG];
  logic [NTERM-1:0] kcol [NREG];
  logic [NTERM-1:0] gcol [NCMP];
  logic [NREG-1:0]  j_vec, k_vec, regs, nxt, pat, pat_shift;
  logic [LW-1:0]    j_lo, k_lo, pat_lo;

  wire oe_mode  = cfg_q[0];
  wire split    = cfg_q[1];
  wire init_act = init_pin & ~oe_mode;
  wire clk_hi   = (split & ~cfg_en) ? din[CLK2_BIT] : clk;

  function automatic logic [LW-1:0] lo_of(input logic [NREG-1:0] v);
    return {v[NST +: HO], v[0 +: HS]};
  endfunction

  function automatic logic [HW-1:0] hi_of(input logic [NREG-1:0] v);
    return {v[NST+HO +: NOUT-HO], v[HS +: NST-HS]};
  endfunction

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[CW-2:0], cfg_din};

  assign pat       = cfg_q[OPTW +: NREG];
  assign pat_shift = cfg_q[OPTW-1 +: NREG];

  assign st_q  = {hi_q[NST-HS-1:0], lo_q[HS-1:0]};
  assign out_q = {hi_q[HW-1:NST-HS], lo_q[LW-1:HS]};
  assign regs  = {out_q, st_q};
  assign xb    = {st_q, din & ~(NIN'(split) << CLK2_BIT)};

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    for (genvar v = 0; v < NVAR; v++) begin : g_lit
      assign apos[t][v] = cfg_q[BASE + t*TW + 2*v];
      assign aneg[t][v] = cfg_q[BASE + t*TW + 2*v + 1];
    end
    for (genvar r = 0; r < NREG; r++) begin : g_or
      assign jcol[r][t] = cfg_q[BASE + t*TW + 2*NVAR + r];
      assign kcol[r][t] = cfg_q[BASE + t*TW + 2*NVAR + NREG + r];
    end
    for (genvar c = 0; c < NCMP; c++) begin : g_grp
      assign gcol[c][t] = cfg_q[BASE + t*TW + 2*NVAR + 2*NREG + c];
    end
    assign term_nc[t] = ~|((apos[t][NB-1:0] & ~xb) | (aneg[t][NB-1:0] & xb));
    assign term[t]    = term_nc[t] &
                        ~|((apos[t][NVAR-1:NB] & ~cvar) | (aneg[t][NVAR-1:NB] & cvar));
  end

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    assign cvar[c] = ~|(term_nc & gcol[c]);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_jk
    assign j_vec[r] = |(term & jcol[r]);
    assign k_vec[r] = |(term & kcol[r]);
  end

  assign nxt = (j_vec & ~regs) | (~k_vec & regs);

  always_ff @(posedge clk or negedge por_n or posedge init_act)
    if (!por_n)        lo_q <= '1;
    else if (init_act) lo_q <= lo_of(pat);
    else if (cfg_en)   lo_q <= lo_of(pat_shift);
    else               lo_q <= lo_of(nxt);

  always_ff @(posedge clk_hi or negedge por_n or posedge init_act)
    if (!por_n)        hi_q <= '1;
    else if (init_act) hi_q <= hi_of(pat);
    else if (cfg_en)   hi_q <= hi_of(pat_shift);
    else               hi_q <= hi_of(nxt);

  assign f_pin = (oe_mode & ~init_pin) ? 'z : out_q;

  assign j_lo   = lo_of(j_vec);
  assign k_lo   = lo_of(k_vec);
  assign pat_lo = lo_of(pat);
endmodule

// File: rtl/mealy_seq_array_chk.sv
module mealy_seq_array_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          cfg_en,
  input logic          init_act,
  input logic [LW-1:0] j_lo,
  input logic [LW-1:0] k_lo,
  input logic [LW-1:0] pat_lo,
  input logic [LW-1:0] lo_q
);
  for (genvar i = 0; i < LW; i++) begin : g_bit
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!por_n || init_act)
      (!cfg_en && !j_lo[i] && !k_lo[i]) |=> lo_q[i] == $past(lo_q[i]));
    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (!por_n || init_act)
      (!cfg_en && j_lo[i] && k_lo[i]) |=> lo_q[i] != $past(lo_q[i]));
    // R3
    set_chk: assert property (@(posedge clk) disable iff (!por_n || init_act)
      (!cfg_en && j_lo[i] && !k_lo[i]) |=> lo_q[i]);
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!por_n || init_act)
      (!cfg_en && !j_lo[i] && k_lo[i]) |=> !lo_q[i]);
  end

  // R5
  init_force_chk: assert property (@(posedge clk) disable iff (!por_n)
    init_act |-> lo_q == pat_lo);

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!por_n || init_act)
    cfg_en |=> lo_q == pat_lo);
endmodule

bind mealy_seq_array mealy_seq_array_chk #(.LW(LW)) u_chk (
  .clk(clk), .por_n(por_n), .cfg_en(cfg_en), .init_act(init_act),
  .j_lo(j_lo), .k_lo(k_lo), .pat_lo(pat_lo), .lo_q(lo_q)
);

// File: tb/mealy_seq_array_tb.sv
module mealy_seq_array_tb;
  localparam int CW = 18 + 64*86;
  localparam logic [15:0] LOM = 16'h0F0F;
  localparam logic [15:0] HIM = 16'hF0F0;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [15:0] din = '0;
  logic init_pin = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  wire  [7:0] f_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [25:0] tpos [64];
  logic [25:0] tneg [64];
  logic [15:0] tj [64];
  logic [15:0] tk [64];
  logic [1:0]  tg [64];
  logic [1:0]  mopt;
  logic [15:0] mpat;
  logic [15:0] mreg;
  logic [15:0] lfsr = 16'hACE1;

  mealy_seq_array u_dut (
    .clk(clk), .por_n(por_n), .din(din), .init_pin(init_pin),
    .cfg_en(cfg_en), .cfg_din(cfg_din), .f_pin(f_pin)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void clear_prog();
    for (int t = 0; t < 64; t++) begin
      tpos[t] = '0; tneg[t] = '0; tj[t] = '0; tk[t] = '0; tg[t] = '0;
    end
    mopt = '0;
    mpat = '0;
  endfunction

  function automatic logic cfg_bit(int p);
    int t, o;
    if (p < 2)  return mopt[p];
    if (p < 18) return mpat[p-2];
    t = (p - 18) / 86;
    o = (p - 18) % 86;
    if (o < 52) return (o % 2) ? tneg[t][o/2] : tpos[t][o/2];
    if (o < 68) return tj[t][o-52];
    if (o < 84) return tk[t][o-68];
    return tg[t][o-84];
  endfunction

  function automatic bit t_on(int t, logic [15:0] d, logic [15:0] r, logic [1:0] cv, bit usec);
    logic x;
    for (int v = 0; v < 26; v++) begin
      if (v >= 24 && !usec) continue;
      x = (v < 16) ? d[v] : (v < 24) ? r[v-16] : cv[v-24];
      if (tpos[t][v] && !x) return 0;
      if (tneg[t][v] && x) return 0;
    end
    return 1;
  endfunction

  function automatic logic [15:0] next_regs(logic [15:0] d, logic [15:0] r);
    logic [15:0] de, nx;
    logic [1:0] cv;
    bit on [64];
    bit j, k;
    de = mopt[1] ? (d & 16'hFFDF) : d;
    cv = 2'b11;
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 64; t++)
        if (tg[t][c] && t_on(t, de, r, cv, 0)) cv[c] = 1'b0;
    for (int t = 0; t < 64; t++) on[t] = t_on(t, de, r, cv, 1);
    for (int i = 0; i < 16; i++) begin
      j = 0; k = 0;
      for (int t = 0; t < 64; t++)
        if (on[t]) begin
          if (tj[t][i]) j = 1;
          if (tk[t][i]) k = 1;
        end
      nx[i] = (j && k) ? !r[i] : j ? 1'b1 : k ? 1'b0 : r[i];
    end
    return nx;
  endfunction

  function automatic logic [7:0] exp_f();
    return (mopt[0] && !init_pin) ? 8'hzz : mreg[15:8];
  endfunction

  task automatic chk(string req);
    logic [7:0] e;
    e = exp_f();
    checks++;
    if (f_pin !== e) begin
      errors++;
      $display("FAIL %s: f_pin=%b expected=%b", req, f_pin, e);
    end
  endtask

  task automatic chk_bit(string req, int b, logic v);
    checks++;
    if (f_pin[b] !== v) begin
      errors++;
      $display("FAIL %s: f_pin[%0d]=%b expected=%b", req, b, f_pin[b], v);
    end
  endtask

  // starts in the low phase of clk, returns at the next falling edge
  task automatic tick(logic [15:0] d, string req);
    logic [15:0] nx;
    din = d;
    nx = next_regs(d, mreg);
    @(posedge clk);
    if (init_pin && !mopt[0]) mreg = mpat;
    else if (mopt[1])         mreg = (mreg & HIM) | (nx & LOM);
    else                      mreg = nx;
    @(negedge clk);
    chk(req);
  endtask

  // second-clock pulse, kept inside the low phase of clk
  task automatic pulse_hi(logic [15:0] d, string req);
    logic [15:0] nx;
    din = d & 16'hFFDF;
    nx = next_regs(din, mreg);
    #1 din[5] = 1'b1;
    #2 mreg = (mreg & LOM) | (nx & HIM);
    chk(req);
    #1 din[5] = 1'b0;
  endtask

  task automatic program_cfg();
    din = '0;
    cfg_en = 1'b1;
    for (int p = CW - 1; p >= 0; p--) begin
      cfg_din = cfg_bit(p);
      @(posedge clk);
      @(negedge clk);
    end
    cfg_en = 1'b0;
    mreg = mpat;
    #1 chk("R8 pattern after load");
  endtask

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  function automatic void detector_prog(logic [1:0] opt);
    clear_prog();
    tpos[0][0]  = 1; tj[0][0] = 1;
    tneg[1][0]  = 1; tk[1][0] = 1;
    tpos[2][16] = 1; tj[2][1] = 1;
    tneg[3][16] = 1; tk[3][1] = 1;
    tpos[4][0] = 1; tneg[4][16] = 1; tpos[4][17] = 1; tj[4][8] = 1;
    tpos[5][0] = 1; tneg[5][16] = 1; tpos[5][17] = 1; tg[5][0] = 1;
    tpos[6][24] = 1; tk[6][8] = 1;
    tpos[7][1] = 1; tj[7][9] = 1; tk[7][9] = 1;
    tpos[8][2] = 1; tj[8][12] = 1; tk[8][12] = 1;
    tpos[9][3] = 1; tneg[9][3] = 1; tj[9][11] = 1;
    tpos[10][5] = 1; tj[10][13] = 1;
    mpat = 16'h0400;
    mopt = opt;
  endfunction

  initial begin
    logic [15:0] bits0;
    clear_prog();
    mreg = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 power-on preset");
    por_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(rnd() & 16'hFFDF, "R1 cleared config holds");

    detector_prog(2'b00);
    program_cfg();

    bits0 = 16'b0101_0011_0110_1101;
    for (int i = 0; i < 16; i++)
      tick({14'd0, (i % 3 == 0), bits0[i]}, "R4 detector trace");
    tick(16'h0001, "R4 detector");
    tick(16'h0000, "R4 detector");
    tick(16'h0001, "R4 detector");
    chk_bit("R4 set on 101", 0, 1'b1);
    tick(16'h0001, "R4 detector");
    chk_bit("R4 else-clear", 0, 1'b0);
    tick(16'h0002, "R3 toggle");
    tick(16'h0002, "R3 toggle");
    for (int i = 0; i < 40; i++) tick(rnd() & 16'h002F, "R3 random trace");
    chk_bit("R2 never-firing term", 3, 1'b0);
    chk_bit("R3 unconnected bit holds", 2, 1'b1);
    chk_bit("R7 din5 ordinary input", 5, mreg[13]);

    init_pin = 1'b1;
    #2 mreg = mpat;
    chk("R5 async force");
    tick(16'h0007, "R5 held while high");
    init_pin = 1'b0;
    #2 chk("R5 released");
    for (int i = 0; i < 6; i++) tick(rnd() & 16'h000F, "R5 resumes");

    detector_prog(2'b01);
    program_cfg();
    tick(16'h0002, "R6 high impedance");
    init_pin = 1'b1;
    #2 chk("R6 driven");
    for (int i = 0; i < 8; i++) tick(rnd() & 16'h000F, "R6 no init in OE mode");
    tick(16'h0002, "R6 toggle visible");
    init_pin = 1'b0;
    #2 chk("R6 disabled again");

    detector_prog(2'b10);
    program_cfg();
    for (int i = 0; i < 4; i++) tick(16'h0005, "R7 upper ignores clk");
    chk_bit("R7 upper still at pattern", 4, 1'b0);
    pulse_hi(16'h0004, "R7 upper toggles on din5");
    chk_bit("R7 out4 toggled", 4, 1'b1);
    pulse_hi(16'h0000, "R7 upper holds");
    chk_bit("R7 din5 masked in array", 5, 1'b0);
    for (int i = 0; i < 10; i++) begin
      tick(rnd() & 16'h000F, "R7 lower on clk");
      pulse_hi(rnd() & 16'h000F, "R7 upper on din5");
    end

    por_n = 1'b0;
    clear_prog();
    mreg = 16'hFFFF;
    #2 chk("R1 reset while running");
    @(negedge clk);
    por_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(rnd() & 16'hFFDF, "R1 holds after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule